// File: doc/BRIEF.md
# Successive-Approximation ADC Controller

This block is the digital half of an 8-bit successive-approximation converter, sitting on a small 8-bit peripheral register bus. Software writes a control register to power the converter, enable its interrupt and launch a conversion. The block then derives a step enable from the system clock divided by twelve and walks a binary search from the most significant bit down. On each step it drives a trial code to an external DAC and comparator, and it reads back one compare bit.

After the eighth decision the code lands in a read-only result register and the end-of-conversion flag sets. If the interrupt is enabled, a level interrupt is raised. Every conversion needs its own start write. A start write during a busy conversion throws the old one away and begins again from the MSB. The analog parts, pin muxing and sample-and-hold live outside this block.

Top module: `sar_adc_ctrl`

## Requirements
- R1: Address 0 is the control register: bit 7 interrupt enable, bit 6 end-of-conversion flag (read-only), bit 5 start (write-only), bit 4 power (1 = on), bits 3:0 read 0. Address 1 is the result register. After reset, control reads 40h, result reads 00h and irq_o is 0.
- R2: A control write with start=1 and power=1 clears the end-of-conversion flag from the next cycle on. The start bit always reads 0.
- R3: Each bit decision takes 12 clocks. The flag reads 0 through clock edge 95 after the start write edge and reads 1 from edge 96 on.
- R4: The search runs MSB first. The first trial code is 80h. When cmp_i=1 (input at or above the trial) the trial bit is kept, otherwise it is cleared. The final result equals the input value of the comparator model.
- R5: A start write during a conversion restarts from 80h at once. The flag then sets 96 edges after the second write, and the result reflects only the new conversion.
- R6: After a conversion ends, no new one begins without another start write. Result, flag and trial_o stay unchanged.
- R7: irq_o is high exactly while interrupt enable and the flag are both 1. It drops on a start write.
- R8: A start written with power=0 is ignored: the flag and result are unchanged. Writing power=0 mid-conversion abandons it, and the flag stays 0.
- R9: Writes to address 1 have no effect on the result register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 control, 1 result |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register |
| trial_o | output | 8 | Trial code to the external DAC |
| cmp_i | input | 1 | Comparator: 1 when input is at or above the trial |
| irq_o | output | 1 | End-of-conversion interrupt level |

## Verification
On every cycle the assertions check a set of local rules:
- the spacing of step ticks, and that a start clears the flag and reloads 80h;
- that at most one trial bit is pending, and that a completion sets the flag and copies the trial code into the result;
- that the engine is idle while powered down, that the idle trial code holds still, that the interrupt only rises after a completion or a control write, and that result writes are ignored.

Only the bench's scenarios can show the end-to-end behaviour. This covers the exact 96-cycle latency, correct codes for a spread of input values including 00h and FFh, the mid-conversion restart, ignored starts while off, and the interrupt's masking.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned CLK_DIV = 12;
  // control register field positions
  localparam int unsigned IE_BIT  = 7;
  localparam int unsigned EOC_BIT = 6;
  localparam int unsigned STA_BIT = 5;
  localparam int unsigned PWR_BIT = 4;
  localparam logic [7:0]  CTRL_RST = 8'h40;
  localparam logic        ADDR_CTRL = 1'b0;
  localparam logic        ADDR_RES  = 1'b1;
endpackage

// File: rtl/sar_adc_clkdiv.sv
module sar_adc_clkdiv #(
  parameter int unsigned CLK_DIV = sar_adc_pkg::CLK_DIV
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // R3: steps are spaced by the divider
  a_r3_tick_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  a_r3_clr_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !tick_o);
endmodule

// File: rtl/sar_adc_engine.sv
module sar_adc_engine #(
  parameter int unsigned DATA_W = sar_adc_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              tick_i,
  input  logic              cmp_i,
  output logic [DATA_W-1:0] trial_o,
  output logic [DATA_W-1:0] result_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [DATA_W-1:0] MSB_ONLY = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] code_q, mask_q, result_q;

  assign busy_o   = |mask_q;
  assign trial_o  = code_q | mask_q;
  assign result_o = result_q;
  assign done_o   = busy_o & tick_i & mask_q[0] & ~start_i & ~abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      mask_q <= '0;
    end else if (start_i) begin
      code_q <= '0;
      mask_q <= MSB_ONLY;
    end else if (abort_i) begin
      mask_q <= '0;
    end else if (busy_o && tick_i) begin
      if (cmp_i) code_q <= code_q | mask_q;
      mask_q <= mask_q >> 1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     result_q <= '0;
    else if (done_o) result_q <= code_q | (cmp_i ? mask_q : '0);
  end

  a_r4_one_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mask_q));
  a_r5_start_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (trial_o == MSB_ONLY));
  a_r4_result_is_trial: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (result_o == trial_o) && !busy_o);
  a_r6_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(trial_o) && !busy_o);
endmodule

// File: rtl/sar_adc_regs.sv
module sar_adc_regs #(
  parameter int unsigned DATA_W = sar_adc_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              done_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              start_o,
  output logic              abort_o,
  output logic [7:0]        rdata_o,
  output logic              irq_o
);
  import sar_adc_pkg::*;

  logic ctrl_wr;
  logic ie_q, eoc_q, pwr_q;
  logic unused_wdata;

  assign unused_wdata = ^{wdata_i[3:0]};
  assign ctrl_wr = wr_en_i && (addr_i == ADDR_CTRL);
  // start only counts when the same write keeps power on
  assign start_o = ctrl_wr & wdata_i[STA_BIT] & wdata_i[PWR_BIT];
  assign abort_o = ctrl_wr & ~wdata_i[PWR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q  <= CTRL_RST[IE_BIT];
      eoc_q <= CTRL_RST[EOC_BIT];
      pwr_q <= CTRL_RST[PWR_BIT];
    end else begin
      if (ctrl_wr) begin
        ie_q  <= wdata_i[IE_BIT];
        pwr_q <= wdata_i[PWR_BIT];
      end
      if (start_o)     eoc_q <= 1'b0;
      else if (done_i) eoc_q <= 1'b1;
    end
  end

  assign irq_o = ie_q & eoc_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CTRL) begin
      rdata_o[IE_BIT]  = ie_q;
      rdata_o[EOC_BIT] = eoc_q;
      rdata_o[PWR_BIT] = pwr_q;
    end else begin
      rdata_o = 8'(result_i);
    end
  end

  a_r2_start_clears_eoc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !eoc_q);
  a_r3_done_sets_eoc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> eoc_q);
  a_r8_off_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_q |-> !busy_i);
  a_r7_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(done_i) || $past(ctrl_wr)));
  a_r9_result_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_RES && !done_i) |=> $stable(result_i));
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int unsigned DATA_W  = sar_adc_pkg::DATA_W,
  parameter int unsigned CLK_DIV = sar_adc_pkg::CLK_DIV
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [DATA_W-1:0] trial_o,
  input  logic              cmp_i,
  output logic              irq_o
);
  logic start_w, abort_w, tick_w, busy_w, done_w;
  logic [DATA_W-1:0] result_w;

  sar_adc_clkdiv #(.CLK_DIV(CLK_DIV)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (start_w),
    .tick_o(tick_w)
  );

  sar_adc_engine #(.DATA_W(DATA_W)) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_w),
    .abort_i (abort_w),
    .tick_i  (tick_w),
    .cmp_i   (cmp_i),
    .trial_o (trial_o),
    .result_o(result_w),
    .busy_o  (busy_w),
    .done_o  (done_w)
  );

  sar_adc_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .done_i  (done_w),
    .busy_i  (busy_w),
    .result_i(result_w),
    .start_o (start_w),
    .abort_o (abort_w),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );
endmodule

// File: tb/sar_adc_ctrl_tb_top.sv
module sar_adc_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, trial;
  logic [7:0] target = '0;
  logic       irq;
  logic       cmp;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;
  assign cmp = (target >= trial);

  sar_adc_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .trial_o(trial), .cmp_i(cmp), .irq_o(irq)
  );

  // {interrupt enable, target}
  localparam logic [8:0] VEC_TAB [0:7] = '{
    9'h000, 9'h1FF, 9'h080, 9'h17F, 9'h055, 9'h1AA, 9'h001, 9'h0C3
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] keep;
    wait_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(1'b0, v); check("R1 ctrl reset", v, 8'h40);
    rd(1'b1, v); check("R1 result reset", v, 8'h00);
    check("R1 irq reset", {7'b0, irq}, 8'h00);

    // table-driven conversions
    for (int i = 0; i < 8; i++) begin
      logic ie;
      ie = VEC_TAB[i][8];
      target = VEC_TAB[i][7:0];
      wr(1'b0, {ie, 1'b0, 1'b1, 1'b1, 4'h0});
      check("R4 first trial 80h", trial, 8'h80);
      rd(1'b0, v); check("R2 eoc cleared, start reads 0", v, {ie, 3'b001, 4'h0});
      check("R7 irq low after start", {7'b0, irq}, 8'h00);
      wait_cyc(95);
      rd(1'b0, v); check("R3 eoc still 0 at edge 95", {7'b0, v[6]}, 8'h00);
      wait_cyc(1);
      rd(1'b0, v); check("R3 eoc set at edge 96", {7'b0, v[6]}, 8'h01);
      rd(1'b1, v); check("R4 result equals input", v, VEC_TAB[i][7:0]);
      check("R7 irq = ie & eoc", {7'b0, irq}, {7'b0, ie});
    end

    // R6 no re-trigger
    keep = trial;
    target = 8'h11;
    wait_cyc(300);
    rd(1'b0, v); check("R6 eoc held", {7'b0, v[6]}, 8'h01);
    rd(1'b1, v); check("R6 result held", v, 8'hC3);
    check("R6 trial held", trial, keep);

    // R5 restart mid-conversion
    target = 8'h3C;
    wr(1'b0, 8'h30);
    wait_cyc(50);
    target = 8'hE7;
    wr(1'b0, 8'h30);
    check("R5 restart trial 80h", trial, 8'h80);
    wait_cyc(95);
    rd(1'b0, v); check("R5 eoc 0 before restart completes", {7'b0, v[6]}, 8'h00);
    wait_cyc(1);
    rd(1'b0, v); check("R5 eoc set 96 after restart", {7'b0, v[6]}, 8'h01);
    rd(1'b1, v); check("R5 result of new conversion", v, 8'hE7);

    // R9 result write ignored
    wr(1'b1, 8'h5A);
    rd(1'b1, v); check("R9 result unchanged by write", v, 8'hE7);

    // R8 start while powered down ignored
    wr(1'b0, 8'h80);
    target = 8'h01;
    wr(1'b0, 8'hA0);
    rd(1'b0, v); check("R8 start with power off keeps eoc", v, 8'hC0);
    check("R7 irq stays with ie and eoc", {7'b0, irq}, 8'h01);
    wait_cyc(120);
    rd(1'b1, v); check("R8 result unchanged when off", v, 8'hE7);

    // R8 power-down mid-conversion abandons
    wr(1'b0, 8'h30);
    wait_cyc(40);
    wr(1'b0, 8'h00);
    wait_cyc(120);
    rd(1'b0, v); check("R8 abandoned conversion eoc 0", v, 8'h00);
    rd(1'b1, v); check("R8 abandoned result unchanged", v, 8'hE7);

    // R7 irq clears on start write
    target = 8'h9D;
    wr(1'b0, 8'hB0);
    check("R7 irq low on start", {7'b0, irq}, 8'h00);
    wait_cyc(96);
    check("R7 irq high at end", {7'b0, irq}, 8'h01);
    rd(1'b1, v); check("R4 result 9Dh", v, 8'h9D);

    // R1 reset mid-conversion
    wr(1'b0, 8'hB0);
    wait_cyc(30);
    rst_n = 1'b0;
    #1;
    rd(1'b0, v); check("R1 reset ctrl 40h", v, 8'h40);
    check("R1 reset irq 0", {7'b0, irq}, 8'h00);
    rd(1'b1, v); check("R1 reset result 00h", v, 8'h00);
    wait_cyc(2);
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule